// File: doc/BRIEF.md
# Rectangle Fill and Bitmap Expansion Engine

This engine takes 64-bit command words from a host, one per valid/ready handshake. It draws into a 24-bit-per-pixel framebuffer through a single pixel access port. The host loads a colour index, a start corner, a stop corner and a drawing mode. A go command then paints a solid rectangle. Separately, a stream of 8-bit bitmap groups can be expanded at a drawing cursor that moves through the start/stop window and wraps. Set bits take the current colour. Clear bits leave the pixel as it was.

The colour index is shown on an output and turned into RGB by an external palette that answers in the same cycle. Rows are laid out bottom-up: screen row 0 sits at the top of the address space. While an operation runs, the engine holds `busy` and refuses new commands. Reset (`rst_n`) is asserted asynchronously and is expected to be released in step with `clk`.

Top module: `fill_expand_engine`

## Requirements
- R1: After reset the engine is idle. `cmd_ready` is 1, `busy` is 0, `fb_req` is 0 and `pal_idx` is 0. No drawing mode is selected, so a go command draws nothing.
- R2: A word whose bits [55:32] equal 0x185C04 loads the colour index from bits [19:12]. The new index appears on `pal_idx` from the cycle after acceptance. Bits [63:56] are not decoded.
- R3: A word with bits [55:32] = 0x184604 sets the start corner, with x in bits [31:16] and y in bits [15:0]. It also moves the bitmap cursor to that corner.
- R4: A word with bits [55:32] = 0x184704 sets the stop corner from the same fields. It leaves the cursor where it is.
- R5: A start or stop x of 1280 or more, or a y of 1024 or more, is stored as 0.
- R6: The exact word 0x0019100400018000 selects rectangle mode. In that mode, the exact word 0x001C130400000018 (go) writes the palette colour to every pixel from the start corner to the stop corner, both included. It moves along x first, then y, one write per clock.
- R7: Go draws nothing when bitmap mode (exact word 0x0019100400418008) is selected, or when start x > stop x, or when start y > stop y.
- R8: A word with bits [55:32] = 0x1C7004 expands bits [31:24] over 8 pixels, bit 31 first. For each pixel the engine reads the pixel and waits for `fb_rvalid`. It then writes back either the colour (bit set) or the data it read (bit clear). The pixels go to the group base address plus 3·i.
- R9: Each of the 8 bitmap pixels advances the cursor x. When x passes stop x it returns to start x and y advances. When y passes stop y it returns to start y. A group's base is the cursor when the group is accepted.
- R10: A word that matches none of the patterns above changes nothing.
- R11: While an operation is in progress `busy` is 1 and `cmd_ready` is 0, so a command offered then is held off rather than lost. The command takes effect only once it is accepted.
- R12: The byte address of pixel (x, y) is (1280·(1023−y)+x)·3, and every access address is a multiple of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host offers a command word |
| cmd_ready | output | 1 | Engine accepts the word this cycle |
| cmd_word | input | 64 | Command word |
| pal_idx | output | 8 | Current colour index to the palette |
| pal_rgb | input | 24 | Palette colour for `pal_idx`, same cycle |
| fb_req | output | 1 | Framebuffer access this cycle |
| fb_we | output | 1 | 1 = write, 0 = read |
| fb_addr | output | 22 | Byte address of the pixel |
| fb_wdata | output | 24 | Pixel data for a write |
| fb_rdata | input | 24 | Pixel data returned by a read |
| fb_rvalid | input | 1 | `fb_rdata` is valid |
| busy | output | 1 | Fill or bitmap group in progress |

## Verification
The checks assume the framebuffer takes a request every clock without back-pressure. They also assume each read gets exactly one `fb_rvalid` some cycles later, and that `pal_rgb` settles in the same cycle as `pal_idx`. The bench's memory model answers each read one clock after the request and accepts writes at once. It offers commands only through the handshake and keeps `cmd_word` stable until it is accepted. The windows are kept small, so a full fill or a wrapping cursor run ends within a few hundred clocks.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic [2:0] {
    K_NONE, K_COLOR, K_START, K_STOP, K_MODE_RECT, K_MODE_BM, K_GO, K_BITS
  } cmd_kind_e;

  typedef enum logic [1:0] { M_NONE, M_RECT, M_BITMAP } draw_mode_e;

  typedef enum logic [2:0] { S_IDLE, S_FILL, S_RD, S_WAIT, S_WR } eng_state_e;

  localparam logic [23:0] OP_COLOR = 24'h185C04;
  localparam logic [23:0] OP_START = 24'h184604;
  localparam logic [23:0] OP_STOP  = 24'h184704;
  localparam logic [23:0] OP_BITS  = 24'h1C7004;
  localparam logic [63:0] W_RECT   = 64'h0019100400018000;
  localparam logic [63:0] W_BITMAP = 64'h0019100400418008;
  localparam logic [63:0] W_GO     = 64'h001C130400000018;

endpackage

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode
  import fe_pkg::*;
(
  input  logic [63:0] word,
  output cmd_kind_e   kind
);
  logic [23:0] op;
  assign op = word[55:32];

  always_comb begin
    kind = K_NONE;
    if (word == W_RECT)        kind = K_MODE_RECT;
    else if (word == W_BITMAP) kind = K_MODE_BM;
    else if (word == W_GO)     kind = K_GO;
    else if (op == OP_COLOR)   kind = K_COLOR;
    else if (op == OP_START)   kind = K_START;
    else if (op == OP_STOP)    kind = K_STOP;
    else if (op == OP_BITS)    kind = K_BITS;
  end
endmodule

// File: rtl/fe_pix_addr.sv
module fe_pix_addr #(
  parameter int SCR_W  = 1280,
  parameter int SCR_H  = 1024,
  parameter int ADDR_W = 22,
  localparam int XW = $clog2(SCR_W),
  localparam int YW = $clog2(SCR_H)
) (
  input  logic [XW-1:0]     x,
  input  logic [YW-1:0]     y,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] row, lin;

  always_comb begin
    row  = ADDR_W'(SCR_H - 1) - ADDR_W'(y);
    lin  = row * ADDR_W'(SCR_W) + ADDR_W'(x);
    addr = lin + (lin << 1);
  end
endmodule

// File: rtl/fill_expand_engine.sv
module fill_expand_engine
  import fe_pkg::*;
#(
  parameter int SCR_W  = 1280,
  parameter int SCR_H  = 1024,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [63:0]       cmd_word,
  output logic [7:0]        pal_idx,
  input  logic [23:0]       pal_rgb,
  output logic              fb_req,
  output logic              fb_we,
  output logic [ADDR_W-1:0] fb_addr,
  output logic [23:0]       fb_wdata,
  input  logic [23:0]       fb_rdata,
  input  logic              fb_rvalid,
  output logic              busy
);
  localparam int XW    = $clog2(SCR_W);
  localparam int YW    = $clog2(SCR_H);
  localparam int GROUP = 8;
  localparam int IW    = $clog2(GROUP);

  eng_state_e        st_q, st_d;
  draw_mode_e        mode_q, mode_d;
  logic [7:0]        col_q, col_d;
  logic [XW-1:0]     sx_q, sx_d, ex_q, ex_d, cx_q, cx_d, px_q, px_d;
  logic [YW-1:0]     sy_q, sy_d, ey_q, ey_d, cy_q, cy_d, py_q, py_d;
  logic [GROUP-1:0]  bits_q, bits_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [23:0]       rd_q, rd_d;

  cmd_kind_e         kind;
  logic              accept;
  logic [XW-1:0]     ax, fx;
  logic [YW-1:0]     ay, fy;
  logic [ADDR_W-1:0] pix_addr, grp_addr;

  function automatic logic [XW-1:0] clamp_x(input logic [15:0] v);
    return (v >= 16'(SCR_W)) ? '0 : v[XW-1:0];
  endfunction

  function automatic logic [YW-1:0] clamp_y(input logic [15:0] v);
    return (v >= 16'(SCR_H)) ? '0 : v[YW-1:0];
  endfunction

  fe_cmd_decode u_dec (.word(cmd_word), .kind(kind));

  assign ax = (st_q == S_FILL) ? px_q : cx_q;
  assign ay = (st_q == S_FILL) ? py_q : cy_q;

  fe_pix_addr #(.SCR_W(SCR_W), .SCR_H(SCR_H), .ADDR_W(ADDR_W)) u_addr (
    .x(ax), .y(ay), .addr(pix_addr)
  );

  assign grp_addr  = base_q + (ADDR_W'(idx_q) << 1) + ADDR_W'(idx_q);
  assign cmd_ready = (st_q == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign busy      = (st_q != S_IDLE);
  assign pal_idx   = col_q;
  assign fx        = clamp_x(cmd_word[31:16]);
  assign fy        = clamp_y(cmd_word[15:0]);

  // next-state process
  always_comb begin
    st_d = st_q;   mode_d = mode_q; col_d = col_q;
    sx_d = sx_q;   sy_d = sy_q;     ex_d = ex_q;   ey_d = ey_q;
    cx_d = cx_q;   cy_d = cy_q;     px_d = px_q;   py_d = py_q;
    bits_d = bits_q; idx_d = idx_q; base_d = base_q; rd_d = rd_q;
    fb_req = 1'b0; fb_we = 1'b0; fb_addr = pix_addr; fb_wdata = pal_rgb;

    unique case (st_q)
      S_IDLE: if (accept) begin
        unique case (kind)
          K_COLOR:     col_d = cmd_word[19:12];
          K_START:     begin sx_d = fx; cx_d = fx; sy_d = fy; cy_d = fy; end
          K_STOP:      begin ex_d = fx; ey_d = fy; end
          K_MODE_RECT: mode_d = M_RECT;
          K_MODE_BM:   mode_d = M_BITMAP;
          K_GO: if (mode_q == M_RECT && sx_q <= ex_q && sy_q <= ey_q) begin
            px_d = sx_q; py_d = sy_q; st_d = S_FILL;
          end
          K_BITS: begin
            bits_d = cmd_word[31:24]; base_d = pix_addr;
            idx_d  = '0;              st_d   = S_RD;
          end
          default: ;
        endcase
      end
      S_FILL: begin
        fb_req = 1'b1; fb_we = 1'b1;
        if (px_q == ex_q) begin
          px_d = sx_q;
          if (py_q == ey_q) st_d = S_IDLE;
          else              py_d = py_q + 1'b1;
        end else begin
          px_d = px_q + 1'b1;
        end
      end
      S_RD: begin
        fb_req = 1'b1; fb_addr = grp_addr; st_d = S_WAIT;
      end
      S_WAIT: if (fb_rvalid) begin
        rd_d = fb_rdata; st_d = S_WR;
      end
      S_WR: begin
        fb_req = 1'b1; fb_we = 1'b1; fb_addr = grp_addr;
        fb_wdata = bits_q[GROUP-1] ? pal_rgb : rd_q;
        bits_d = bits_q << 1;
        idx_d  = idx_q + 1'b1;
        if (cx_q >= ex_q) begin
          cx_d = sx_q;
          cy_d = (cy_q >= ey_q) ? sy_q : cy_q + 1'b1;
        end else begin
          cx_d = cx_q + 1'b1;
        end
        st_d = (idx_q == IW'(GROUP - 1)) ? S_IDLE : S_RD;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; mode_q <= M_NONE; col_q <= '0;
      sx_q <= '0; sy_q <= '0; ex_q <= '0; ey_q <= '0;
      cx_q <= '0; cy_q <= '0; px_q <= '0; py_q <= '0;
      bits_q <= '0; idx_q <= '0; base_q <= '0; rd_q <= '0;
    end else begin
      st_q <= st_d; mode_q <= mode_d; col_q <= col_d;
      sx_q <= sx_d; sy_q <= sy_d; ex_q <= ex_d; ey_q <= ey_d;
      cx_q <= cx_d; cy_q <= cy_d; px_q <= px_d; py_q <= py_d;
      bits_q <= bits_d; idx_q <= idx_d; base_q <= base_d; rd_q <= rd_d;
    end
  end
endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              busy,
  input logic              fb_req,
  input logic [ADDR_W-1:0] fb_addr
);
  AST_NO_IDLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    fb_req |-> busy);                                              // R11
  AST_BUSY_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);                                          // R11
  AST_PIXEL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fb_req |-> (fb_addr % 3 == 0));                                // R12
  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_ready));                // R11
endmodule

bind fill_expand_engine fe_checker #(.ADDR_W(ADDR_W)) u_fe_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .fb_req(fb_req), .fb_addr(fb_addr)
);

// File: tb/sim_fill_expand_engine.sv
`timescale 1ns/1ps
module sim_fill_expand_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [63:0] cmd_word;
  logic [7:0]  pal_idx;
  logic [23:0] pal_rgb;
  logic        fb_req, fb_we, fb_rvalid, busy;
  logic [21:0] fb_addr;
  logic [23:0] fb_wdata, fb_rdata;

  always #10 clk = ~clk;  // 50 MHz

  fill_expand_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
    .fb_req(fb_req), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .fb_rdata(fb_rdata), .fb_rvalid(fb_rvalid), .busy(busy)
  );

  function automatic logic [23:0] pal(input logic [7:0] i);
    return {i, ~i, i ^ 8'h5A};
  endfunction
  assign pal_rgb = pal(pal_idx);

  function automatic int pa(input int x, input int y);
    return (1280 * (1023 - y) + x) * 3;
  endfunction

  // framebuffer model: reads answered one clock later
  logic [23:0] mem [int];
  int          wr_cnt = 0, rd_cnt = 0;
  int          wlog [256];
  int          rlog [256];

  function automatic logic [23:0] peek(input int a);
    return mem.exists(a) ? mem[a] : 24'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      fb_rvalid <= 1'b0;
      fb_rdata  <= '0;
    end else begin
      fb_rvalid <= fb_req && !fb_we;
      if (fb_req && !fb_we) begin
        fb_rdata <= peek(int'(fb_addr));
        rlog[rd_cnt % 256] = int'(fb_addr);
        rd_cnt = rd_cnt + 1;
      end
      if (fb_req && fb_we) begin
        mem[int'(fb_addr)] = fb_wdata;
        wlog[wr_cnt % 256] = int'(fb_addr);
        wr_cnt = wr_cnt + 1;
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [63:0] xy(input logic [23:0] op, input int x, input int y);
    return {8'h00, op, 16'(x), 16'(y)};
  endfunction

  localparam logic [63:0] RECT = 64'h0019100400018000;
  localparam logic [63:0] BMAP = 64'h0019100400418008;
  localparam logic [63:0] GO   = 64'h001C130400000018;

  // stimulus table: word, expected colour index afterwards (R2, R10)
  localparam int NT = 6;
  localparam logic [63:0] TBL_W [NT] = '{
    64'h00185C04_0003C000,   // colour 3C
    64'h00185C05_00045000,   // near miss: ignored
    64'hFF185C04_000AB000,   // top byte not decoded: colour AB
    64'h0019100400018001,    // near mode word: ignored
    64'h00185C04_FFF12FFF,   // colour 12, other bits ignored
    64'h001C130400000018     // go with no mode: nothing
  };
  localparam logic [7:0] TBL_E [NT] = '{8'h3C, 8'h3C, 8'hAB, 8'hAB, 8'h12, 8'h12};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w0, r0, b;
    logic [7:0] pat;
    cmd_valid = 1'b0; cmd_word = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cmd_ready === 1'b1, "R1 ready", cmd_ready, 1);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(fb_req === 1'b0, "R1 fb_req", fb_req, 0);
    chk(pal_idx === 8'h00, "R1 pal_idx", pal_idx, 0);

    // table walk: R2 colour decode, R10 ignored words, R1 no mode
    w0 = wr_cnt;
    for (int i = 0; i < NT; i++) begin
      send(TBL_W[i]);
      wait_idle();
      chk(pal_idx === TBL_E[i], $sformatf("R2/R10 table %0d", i), pal_idx, TBL_E[i]);
    end
    chk(wr_cnt == w0, "R10/R1 table writes", wr_cnt - w0, 0);

    // R6/R12 rectangle (2,5)-(4,6), colour 3
    send(64'h00185C04_00003000);
    send(xy(24'h184604, 2, 5));
    send(xy(24'h184704, 4, 6));
    send(RECT);
    w0 = wr_cnt;
    send(GO);
    wait_idle();
    chk(wr_cnt - w0 == 6, "R6 fill count", wr_cnt - w0, 6);
    chk(wlog[w0 % 256] == pa(2, 5), "R12 first addr", wlog[w0 % 256], pa(2, 5));
    chk(wlog[(w0 + 1) % 256] == pa(3, 5), "R6 x-first order", wlog[(w0 + 1) % 256], pa(3, 5));
    chk(wlog[(w0 + 3) % 256] == pa(2, 6), "R6 next row", wlog[(w0 + 3) % 256], pa(2, 6));
    chk(peek(pa(4, 6)) == pal(8'h03), "R6 corner colour", peek(pa(4, 6)), pal(8'h03));
    chk(peek(pa(5, 5)) == 24'h0, "R6 outside kept", peek(pa(5, 5)), 0);

    // R5 clamping: start (1280,2000)->(0,0), stop (1,1024)->(1,0)
    send(xy(24'h184604, 1280, 2000));
    send(xy(24'h184704, 1, 1024));
    w0 = wr_cnt;
    send(GO);
    wait_idle();
    chk(wr_cnt - w0 == 2, "R5 clamp count", wr_cnt - w0, 2);
    chk(wlog[w0 % 256] == pa(0, 0), "R5 clamp addr", wlog[w0 % 256], pa(0, 0));

    // R7 go in bitmap mode, and inverted window in rect mode
    send(BMAP);
    w0 = wr_cnt;
    send(GO);
    repeat (4) @(negedge clk);
    chk(wr_cnt == w0, "R7 bitmap-mode go", wr_cnt - w0, 0);
    send(RECT);
    send(xy(24'h184604, 5, 0));
    send(xy(24'h184704, 3, 0));
    send(GO);
    repeat (4) @(negedge clk);
    chk(wr_cnt == w0, "R7 inverted window", wr_cnt - w0, 0);

    // R8 bitmap expansion with read-modify-write, window (0,0)-(2,2)
    b = pa(0, 0);
    for (int i = 0; i < 8; i++) mem[b + 3 * i] = 24'h100000 + 24'(i);
    send(64'h00185C04_00009000);
    send(xy(24'h184604, 0, 0));
    send(xy(24'h184704, 2, 2));
    w0 = wr_cnt; r0 = rd_cnt;
    pat = 8'hA5;
    send({8'h00, 24'h1C7004, pat, 24'h0});
    wait_idle();
    chk(rd_cnt - r0 == 8, "R8 reads", rd_cnt - r0, 8);
    chk(wr_cnt - w0 == 8, "R8 writes", wr_cnt - w0, 8);
    chk(rlog[r0 % 256] == b, "R8 group base", rlog[r0 % 256], b);
    for (int i = 0; i < 8; i++) begin
      logic [23:0] e;
      e = pat[7 - i] ? pal(8'h09) : 24'h100000 + 24'(i);
      chk(peek(b + 3 * i) == e, $sformatf("R8 pixel %0d", i), peek(b + 3 * i), e);
    end

    // R4 stop rewrite keeps cursor; R9 cursor now at (2,2)
    send(xy(24'h184704, 2, 2));
    r0 = rd_cnt;
    send({8'h00, 24'h1C7004, 8'h00, 24'h0});
    wait_idle();
    chk(rlog[r0 % 256] == pa(2, 2), "R4/R9 x wrap base", rlog[r0 % 256], pa(2, 2));
    r0 = rd_cnt;
    send({8'h00, 24'h1C7004, 8'hFF, 24'h0});
    wait_idle();
    chk(rlog[r0 % 256] == pa(1, 2), "R9 y wrap base", rlog[r0 % 256], pa(1, 2));
    chk(peek(pa(1, 2)) == pal(8'h09), "R8 set bit colour", peek(pa(1, 2)), pal(8'h09));

    // R3 start reloads cursor
    send(xy(24'h184604, 1, 1));
    r0 = rd_cnt;
    send({8'h00, 24'h1C7004, 8'h00, 24'h0});
    wait_idle();
    chk(rlog[r0 % 256] == pa(1, 1), "R3 cursor reload", rlog[r0 % 256], pa(1, 1));

    // R11 stall: colour change offered during a 100-pixel fill
    send(64'h00185C04_00005000);
    send(xy(24'h184604, 0, 0));
    send(xy(24'h184704, 9, 9));
    send(RECT);
    w0 = wr_cnt;
    send(GO);
    cmd_valid = 1'b1; cmd_word = 64'h00185C04_00077000;
    @(negedge clk);
    chk(busy === 1'b1 && cmd_ready === 1'b0, "R11 held off", {busy, cmd_ready}, 2'b10);
    repeat (20) @(negedge clk);
    chk(pal_idx === 8'h05, "R11 not applied early", pal_idx, 8'h05);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(pal_idx === 8'h77, "R11 applied after", pal_idx, 8'h77);
    chk(wr_cnt - w0 == 100, "R11 fill complete", wr_cnt - w0, 100);
    chk(peek(pa(9, 9)) == pal(8'h05), "R11 fill colour", peek(pa(9, 9)), pal(8'h05));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule